// File: doc/BRIEF.md
# Decrementer Timer with Auto-Reload

This block is a 32-bit down-counter used by system software to schedule a one-shot or periodic timer event. Every cycle in which the time-base tick enable is high, a non-zero count drops by one. When a tick finds the count at 1, the block records a sticky expiry flag. The count then either falls to 0 and rests there, or, if automatic reload is switched on, is refilled from a separate reload register so that the next period begins.

Software owns a small register port. It can write and read the count, write and read the reload value, set the interrupt-enable and reload-enable controls, and clear the expiry flag with a write-one-to-clear strobe. The interrupt output is the expiry flag masked by the interrupt enable. A count write made in the same cycle as an expiring tick still records the expiry, but the written value is what the counter holds afterwards.

Top module: `dec_timer`

## Requirements
- R1: After reset the count, the reload value, both control bits, the expiry flag and the interrupt output are all 0.
- R2: A tick with a count above 1 lowers the count by exactly 1 at that clock edge. A cycle without a tick leaves the count unchanged.
- R3: With reload disabled, a tick at count 1 sets the expiry flag and leaves the count at 0. Further ticks at count 0 change neither the count nor the flag.
- R4: A count write loads the written value at the next edge. Writing 0 without an expiring tick in the same cycle never sets the expiry flag.
- R5: When a count write coincides with a tick at count 1, the expiry flag is set and the count takes the written value, not the reload value and not 0.
- R6: With reload enabled, a tick at count 1 sets the expiry flag and copies the reload register into the count.
- R7: A status write with data bit 1 clears the expiry flag. A status write with data bit 0 leaves it unchanged.
- R8: If an expiring tick and a status clear arrive in the same cycle, the flag ends up set.
- R9: The interrupt output equals the expiry flag ANDed with the interrupt enable. Clearing the enable drops the interrupt and leaves the flag set.
- R10: After reload is disabled again, a tick at count 1 leaves the count at 0, not at the reload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Single-cycle time-base tick enable |
| cnt_wr_en | input | 1 | Count write strobe |
| cnt_wr_data | input | 32 | Value to load into the count |
| rld_wr_en | input | 1 | Reload register write strobe |
| rld_wr_data | input | 32 | New reload value |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_irq_en | input | 1 | New interrupt-enable bit |
| ctl_wr_reload_en | input | 1 | New reload-enable bit |
| sts_wr_en | input | 1 | Status write strobe |
| sts_wr_data | input | 1 | Status write data; 1 clears the expiry flag |
| cnt_value | output | 32 | Current count |
| rld_value | output | 32 | Current reload value |
| irq_en | output | 1 | Current interrupt-enable bit |
| reload_en | output | 1 | Current reload-enable bit |
| expired | output | 1 | Sticky expiry flag |
| irq | output | 1 | Interrupt request |

## Verification
Every register write and every tick acts at the clock edge where it is sampled, so the count, the reload value, the controls and the expiry flag all show the new value one cycle after the stimulus is applied. The interrupt output is combinational from the flag and the enable, so it becomes valid in that same cycle. The bench changes its inputs just after a rising edge, moves through exactly one edge, and samples shortly after that edge. Each check therefore reads the one result its stimulus caused, before any later stimulus arrives.

// File: rtl/dec_timer_pkg.sv
// Package: shared types for the decrementer timer.
// Assumes: nothing beyond standard SystemVerilog.
package dec_timer_pkg;

    // Software control bits of the timer.
    typedef struct packed {
        logic irq_en;
        logic reload_en;
    } dec_ctl_t;

    localparam dec_ctl_t DEC_CTL_RESET = '{irq_en: 1'b0, reload_en: 1'b0};

endpackage

// File: rtl/dec_cfg_regs.sv
// Module: dec_cfg_regs
// Holds the reload value and the control bits that software writes.
// Assumes: write strobes are single-cycle and synchronous to clk.
module dec_cfg_regs
    import dec_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rld_wr_en,
    input  logic [CNT_W-1:0] rld_wr_data,
    input  logic             ctl_wr_en,
    input  dec_ctl_t         ctl_wr_data,
    output logic [CNT_W-1:0] rld_q,
    output dec_ctl_t         ctl_q
);

    // Reload value register.
    always_ff @(posedge clk) begin
        if (!rst_n)         rld_q <= '0;
        else if (rld_wr_en) rld_q <= rld_wr_data;
    end

    // Control bit register.
    always_ff @(posedge clk) begin
        if (!rst_n)         ctl_q <= DEC_CTL_RESET;
        else if (ctl_wr_en) ctl_q <= ctl_wr_data;
    end

endmodule

// File: rtl/dec_counter.sv
// Module: dec_counter
// Down-counter that flags an expiry when a tick finds it at 1.
// Assumes: a software write beats both reload and decrement, and a zero
// count never decrements.
module dec_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             reload_en,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             expire
);

    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    logic [CNT_W-1:0] cnt_d;

    // Detect the 1 -> 0 boundary on a tick.
    always_comb expire = tick_en && (cnt_q == CNT_ONE);

    // Choose the next count: write, then boundary, then plain decrement.
    always_comb begin
        cnt_d = cnt_q;
        if (wr_en)
            cnt_d = wr_data;
        else if (expire)
            cnt_d = reload_en ? reload_val : CNT_ZERO;
        else if (tick_en && (cnt_q != CNT_ZERO))
            cnt_d = cnt_q - CNT_ONE;
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/dec_status.sv
// Module: dec_status
// Sticky expiry flag with write-one-to-clear; a set beats a clear.
// Assumes: set and clear are single-cycle strobes synchronous to clk.
module dec_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_req,
    output logic flag_q
);

    // Hold the flag, apply a clear, and let a set override the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (set_evt) flag_q <= 1'b1;
        else if (clr_req) flag_q <= 1'b0;
    end

endmodule

// File: rtl/dec_timer.sv
// Module: dec_timer (top)
// Decrementer timer with optional auto-reload, a sticky expiry flag and a
// masked interrupt output.
// Assumes: tick_en is a one-cycle enable in the clk domain.
module dec_timer
    import dec_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             cnt_wr_en,
    input  logic [CNT_W-1:0] cnt_wr_data,
    input  logic             rld_wr_en,
    input  logic [CNT_W-1:0] rld_wr_data,
    input  logic             ctl_wr_en,
    input  logic             ctl_wr_irq_en,
    input  logic             ctl_wr_reload_en,
    input  logic             sts_wr_en,
    input  logic             sts_wr_data,
    output logic [CNT_W-1:0] cnt_value,
    output logic [CNT_W-1:0] rld_value,
    output logic             irq_en,
    output logic             reload_en,
    output logic             expired,
    output logic             irq
);

    dec_ctl_t ctl_wr, ctl_q;
    logic     expire_evt;
    logic     sts_clr;

    // Pack the control write data.
    always_comb ctl_wr = '{irq_en: ctl_wr_irq_en, reload_en: ctl_wr_reload_en};

    // Only a written 1 clears the flag.
    always_comb sts_clr = sts_wr_en && sts_wr_data;

    dec_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .rld_wr_en   (rld_wr_en),
        .rld_wr_data (rld_wr_data),
        .ctl_wr_en   (ctl_wr_en),
        .ctl_wr_data (ctl_wr),
        .rld_q       (rld_value),
        .ctl_q       (ctl_q)
    );

    dec_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .wr_en      (cnt_wr_en),
        .wr_data    (cnt_wr_data),
        .reload_en  (ctl_q.reload_en),
        .reload_val (rld_value),
        .cnt_q      (cnt_value),
        .expire     (expire_evt)
    );

    dec_status u_sts (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (expire_evt),
        .clr_req (sts_clr),
        .flag_q  (expired)
    );

    // Drive the control outputs and the masked interrupt.
    always_comb begin
        irq_en    = ctl_q.irq_en;
        reload_en = ctl_q.reload_en;
        irq       = expired && ctl_q.irq_en;
    end

endmodule

// File: rtl/dec_timer_chk.sv
// Module: dec_timer_chk
// Port-level property checker for dec_timer, attached with bind.
// Assumes: it sees the top-level ports only.
module dec_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             cnt_wr_en,
    input logic [CNT_W-1:0] cnt_wr_data,
    input logic             sts_wr_en,
    input logic             sts_wr_data,
    input logic [CNT_W-1:0] cnt_value,
    input logic [CNT_W-1:0] rld_value,
    input logic             irq_en,
    input logic             reload_en,
    input logic             expired,
    input logic             irq
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // R2: a tick above 1 takes exactly one off the count.
    p_decrement_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !cnt_wr_en && cnt_value > ONE) |=> cnt_value == $past(cnt_value) - ONE);

    // R3: without reload, a count of 0 stays at 0 until software writes it.
    p_zero_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_value == '0 && !cnt_wr_en) |=> cnt_value == '0);

    // R4: the flag cannot rise without a tick at 1.
    p_no_spurious_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!expired && !(tick_en && cnt_value == ONE)) |=> !expired);

    // R5: a colliding write wins the count and the expiry is still taken.
    p_collision_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && cnt_value == ONE && cnt_wr_en) |=> (expired && cnt_value == $past(cnt_wr_data)));

    // R6: with reload on, the boundary tick loads the reload value.
    p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && cnt_value == ONE && !cnt_wr_en && reload_en) |=> cnt_value == $past(rld_value));

    // R7: a written 1 clears the flag when no expiry competes.
    p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr_en && sts_wr_data && !(tick_en && cnt_value == ONE)) |=> !expired);

    // R8: an expiring tick sets the flag even against a clear.
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && cnt_value == ONE) |=> expired);

    // R9: the interrupt follows the flag masked by the enable.
    p_irq_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (expired && irq_en));

endmodule

bind dec_timer dec_timer_chk #(.CNT_W(CNT_W)) u_dec_timer_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .cnt_wr_en   (cnt_wr_en),
    .cnt_wr_data (cnt_wr_data),
    .sts_wr_en   (sts_wr_en),
    .sts_wr_data (sts_wr_data),
    .cnt_value   (cnt_value),
    .rld_value   (rld_value),
    .irq_en      (irq_en),
    .reload_en   (reload_en),
    .expired     (expired),
    .irq         (irq)
);

// File: tb/test_dec_timer.sv
// Directed bench for dec_timer: one task per scenario, each checking itself.
module test_dec_timer;

    localparam int CNT_W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick_en = 1'b0;
    logic             cnt_wr_en = 1'b0;
    logic [CNT_W-1:0] cnt_wr_data = '0;
    logic             rld_wr_en = 1'b0;
    logic [CNT_W-1:0] rld_wr_data = '0;
    logic             ctl_wr_en = 1'b0;
    logic             ctl_wr_irq_en = 1'b0;
    logic             ctl_wr_reload_en = 1'b0;
    logic             sts_wr_en = 1'b0;
    logic             sts_wr_data = 1'b0;
    logic [CNT_W-1:0] cnt_value;
    logic [CNT_W-1:0] rld_value;
    logic             irq_en;
    logic             reload_en;
    logic             expired;
    logic             irq;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    dec_timer #(.CNT_W(CNT_W)) i_dec_timer (
        .clk              (clk),
        .rst_n            (rst_n),
        .tick_en          (tick_en),
        .cnt_wr_en        (cnt_wr_en),
        .cnt_wr_data      (cnt_wr_data),
        .rld_wr_en        (rld_wr_en),
        .rld_wr_data      (rld_wr_data),
        .ctl_wr_en        (ctl_wr_en),
        .ctl_wr_irq_en    (ctl_wr_irq_en),
        .ctl_wr_reload_en (ctl_wr_reload_en),
        .sts_wr_en        (sts_wr_en),
        .sts_wr_data      (sts_wr_data),
        .cnt_value        (cnt_value),
        .rld_value        (rld_value),
        .irq_en           (irq_en),
        .reload_en        (reload_en),
        .expired          (expired),
        .irq              (irq)
    );

    task automatic check(input string req, input logic [CNT_W-1:0] act, input logic [CNT_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Move through one edge with the current inputs, sample, then idle the inputs.
    task automatic step();
        @(posedge clk);
        #1;
        tick_en = 1'b0; cnt_wr_en = 1'b0; rld_wr_en = 1'b0;
        ctl_wr_en = 1'b0; sts_wr_en = 1'b0; sts_wr_data = 1'b0;
    endtask

    task automatic wr_cnt(input logic [CNT_W-1:0] v);
        cnt_wr_en = 1'b1; cnt_wr_data = v; step();
    endtask

    task automatic wr_ctl(input logic ie, input logic re);
        ctl_wr_en = 1'b1; ctl_wr_irq_en = ie; ctl_wr_reload_en = re; step();
    endtask

    task automatic clr_sts();
        sts_wr_en = 1'b1; sts_wr_data = 1'b1; step();
    endtask

    task automatic tick();
        tick_en = 1'b1; step();
    endtask

    task automatic t_reset();
        check("R1 count", cnt_value, 0);
        check("R1 reload", rld_value, 0);
        check("R1 irq_en", CNT_W'(irq_en), 0);
        check("R1 reload_en", CNT_W'(reload_en), 0);
        check("R1 flag", CNT_W'(expired), 0);
        check("R1 irq", CNT_W'(irq), 0);
    endtask

    task automatic t_decrement();
        wr_cnt(5);
        check("R4 write", cnt_value, 5);
        tick();
        check("R2 dec", cnt_value, 4);
        step();
        check("R2 hold", cnt_value, 4);
        tick();
        check("R2 dec again", cnt_value, 3);
        check("R2 no flag", CNT_W'(expired), 0);
    endtask

    task automatic t_expire();
        wr_cnt(2);
        tick();
        check("R3 at one", cnt_value, 1);
        tick();
        check("R3 count zero", cnt_value, 0);
        check("R3 flag set", CNT_W'(expired), 1);
        clr_sts();
        tick();
        check("R3 stays zero", cnt_value, 0);
        check("R3 no new flag", CNT_W'(expired), 0);
    endtask

    task automatic t_zero_write();
        wr_cnt(3);
        wr_cnt(0);
        check("R4 zero write", cnt_value, 0);
        check("R4 no flag", CNT_W'(expired), 0);
    endtask

    task automatic t_collision();
        rld_wr_en = 1'b1; rld_wr_data = 900; step();
        wr_ctl(1'b0, 1'b1);
        wr_cnt(1);
        tick_en = 1'b1; cnt_wr_en = 1'b1; cnt_wr_data = 77; step();
        check("R5 written value wins", cnt_value, 77);
        check("R5 flag set", CNT_W'(expired), 1);
        clr_sts();
        wr_ctl(1'b0, 1'b0);
    endtask

    task automatic t_reload();
        rld_wr_en = 1'b1; rld_wr_data = 10; step();
        check("R6 reload reg", rld_value, 10);
        wr_ctl(1'b0, 1'b1);
        wr_cnt(1);
        tick();
        check("R6 reloaded", cnt_value, 10);
        check("R6 flag", CNT_W'(expired), 1);
        tick();
        check("R6 next period", cnt_value, 9);
        clr_sts();
    endtask

    task automatic t_reload_off();
        wr_ctl(1'b0, 1'b0);
        wr_cnt(1);
        tick();
        check("R10 no reload", cnt_value, 0);
        clr_sts();
    endtask

    task automatic t_w1c();
        wr_cnt(1);
        tick();
        check("R7 flag set", CNT_W'(expired), 1);
        sts_wr_en = 1'b1; sts_wr_data = 1'b0; step();
        check("R7 write0 ignored", CNT_W'(expired), 1);
        clr_sts();
        check("R7 write1 clears", CNT_W'(expired), 0);
    endtask

    task automatic t_set_priority();
        wr_cnt(1);
        tick_en = 1'b1; sts_wr_en = 1'b1; sts_wr_data = 1'b1; step();
        check("R8 set beats clear", CNT_W'(expired), 1);
    endtask

    task automatic t_irq();
        check("R9 masked", CNT_W'(irq), 0);
        wr_ctl(1'b1, 1'b0);
        check("R9 irq on", CNT_W'(irq), 1);
        wr_ctl(1'b0, 1'b0);
        check("R9 irq off", CNT_W'(irq), 0);
        check("R9 flag kept", CNT_W'(expired), 1);
        clr_sts();
    endtask

    initial begin
        #(200000 * 20);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        step();
        t_decrement();
        t_expire();
        t_zero_write();
        t_collision();
        t_reload();
        t_reload_off();
        t_w1c();
        t_set_priority();
        t_irq();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule